// File: doc/BRIEF.md
# Equivalent-Time Sampling Clock Generator

This block derives the conversion clock for a slow analog-to-digital converter so that a fast, strictly periodic input signal can be captured in equivalent time. A fast clock runs the block. Software-visible configuration is limited to two inputs. The first is the division ratio, which sets the spacing of sample instants in fast clocks. The second is the period length, which gives how many fast clocks make up one period of the analog signal. Each rising edge of the generated clock is a sample instant.

After a start pulse, the block sweeps over a series of signal periods. Within each period the divided clock fires every division-ratio fast clocks. At every new period the whole pattern is delayed by one more fast clock, and the divider restarts at each period boundary, so no pulse spills into the next period. After as many periods as the division ratio, every phase between two sample instants has been visited. The sweep then stops with a one-cycle completion pulse, because any further period would only repeat samples already taken.

A period index output gives the current phase offset. Reconstruction logic downstream uses it to interleave the captured samples into one dense waveform. A configuration that cannot produce a valid sweep is rejected at once, and no output edge is produced.

Top module: `ets_clock_gen`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs adc_clk, busy and done are 0 and phase_idx is 0 until a start is accepted.
- R2: When start is sampled high while idle with a valid configuration, busy is 1 from the next cycle for exactly div_ratio × period_len cycles. The first busy cycle is position 0 of period 0.
- R3: In busy cycle c, let pos = c mod period_len and p = c / period_len. In that cycle adc_clk is 1 exactly when pos ≥ p and ((pos − p) mod div_ratio) < floor(div_ratio/2). Rising edges therefore fall at positions p, p+div_ratio, … below period_len, and pulses are cut at the period end.
- R4: During busy, phase_idx equals the period index p, which is also the phase offset in fast clocks. It counts 0, 1, … div_ratio−1.
- R5: In the cycle after the last busy cycle, busy is 0, done is 1 for exactly one cycle, adc_clk is 0 and phase_idx returns to 0. After that the outputs stay idle.
- R6: A start with div_ratio of 0 or 1, or with period_len smaller than div_ratio, is rejected. done is 1 in the next cycle, and busy and adc_clk stay 0.
- R7: A start pulse while busy is ignored. The sweep in progress continues unchanged and no second sweep follows.
- R8: The division ratio and the period length are captured when start is accepted. Changing these inputs during a sweep has no effect on adc_clk, busy, done or phase_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins a sweep when sampled high while idle |
| div_ratio | input | CNT_W | Fast clocks between sample instants |
| period_len | input | CNT_W | Fast clocks in one analog-signal period |
| adc_clk | output | 1 | Generated conversion clock, registered |
| busy | output | 1 | High while periods are being swept |
| done | output | 1 | One-cycle pulse at the end of a sweep or on rejection |
| phase_idx | output | CNT_W | Current period index, equal to the phase offset |

## Verification
Sweeps are run with an even ratio whose period is a whole multiple of the ratio. This shows whether the per-period delay is applied. An odd ratio with a period that is not a multiple tests the floor duty and the truncation of pulses at the period end. A period equal to the ratio and a period just above it probe the smallest legal sweeps, where a wrong boundary comparison would add or drop an edge. The rejected cases (ratio 0, ratio 1, period shorter than ratio) and a sweep disturbed by a second start and new configuration values separate an early-return path, or latching of the inputs, from live use of the inputs.

// File: rtl/ets_pkg.sv
package ets_pkg;
  typedef enum logic {
    SWP_IDLE = 1'b0,
    SWP_RUN  = 1'b1
  } swp_state_e;
endpackage

// File: rtl/ets_cfg_check.sv
module ets_cfg_check #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] div_in,
  input  logic [CNT_W-1:0] per_in,
  output logic             cfg_ok
);
  localparam logic [CNT_W-1:0] MIN_DIV = CNT_W'(2);

  always_comb begin
    cfg_ok = (div_in >= MIN_DIV) && (per_in >= div_in);
  end
endmodule

// File: rtl/ets_sweep_ctrl.sv
module ets_sweep_ctrl
  import ets_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_ok,
  input  logic [CNT_W-1:0] div_in,
  input  logic [CNT_W-1:0] per_in,
  output logic             run_q,
  output logic             run_n,
  output logic             done_q,
  output logic [CNT_W-1:0] pos_q,
  output logic [CNT_W-1:0] pos_n,
  output logic [CNT_W-1:0] ph_q,
  output logic [CNT_W-1:0] ph_n,
  output logic [CNT_W-1:0] div_q,
  output logic [CNT_W-1:0] div_n
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  swp_state_e       st_q, st_n;
  logic             done_n;
  logic [CNT_W-1:0] per_q, per_n;
  logic             last_pos, last_ph;

  assign last_pos = (pos_q == per_q - ONE);
  assign last_ph  = (ph_q == div_q - ONE);

  // next-state
  always_comb begin
    st_n   = st_q;
    pos_n  = pos_q;
    ph_n   = ph_q;
    div_n  = div_q;
    per_n  = per_q;
    done_n = 1'b0;
    case (st_q)
      SWP_IDLE: begin
        if (start) begin
          if (cfg_ok) begin
            st_n  = SWP_RUN;
            pos_n = '0;
            ph_n  = '0;
            div_n = div_in;
            per_n = per_in;
          end else begin
            done_n = 1'b1;
          end
        end
      end
      SWP_RUN: begin
        if (last_pos) begin
          pos_n = '0;
          if (last_ph) begin
            st_n   = SWP_IDLE;
            ph_n   = '0;
            done_n = 1'b1;
          end else begin
            ph_n = ph_q + ONE;
          end
        end else begin
          pos_n = pos_q + ONE;
        end
      end
      default: st_n = SWP_IDLE;
    endcase
  end

  assign run_n = (st_n == SWP_RUN);
  assign run_q = (st_q == SWP_RUN);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SWP_IDLE;
      pos_q  <= '0;
      ph_q   <= '0;
      div_q  <= '0;
      per_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      pos_q  <= pos_n;
      ph_q   <= ph_n;
      div_q  <= div_n;
      per_q  <= per_n;
      done_q <= done_n;
    end
  end

  // R5: completion pulse lasts one cycle and never overlaps busy
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && run_q));
  // R4: period index stays below the captured ratio
  a_r4_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (ph_q < div_q) && (pos_q < per_q));
  // R8: captured configuration holds across a sweep
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> ($stable(div_q) && $stable(per_q)));
  // R6: rejected start returns done without a sweep
  a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run_q && !cfg_ok) |=> (done_q && !run_q));
endmodule

// File: rtl/ets_phase_div.sv
module ets_phase_div #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_n,
  input  logic [CNT_W-1:0] pos_n,
  input  logic [CNT_W-1:0] ph_n,
  input  logic [CNT_W-1:0] div_n,
  output logic             clk_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] sub_q, sub_n;
  logic [CNT_W-1:0] half;
  logic             armed;
  logic             clk_n;

  assign half  = div_n >> 1;
  assign armed = run_n && (pos_n >= ph_n);

  // next-state: divider restarts where the period's phase offset is reached
  always_comb begin
    sub_n = '0;
    if (armed && (pos_n != ph_n)) begin
      sub_n = (sub_q == div_n - ONE) ? '0 : sub_q + ONE;
    end
    clk_n = armed && (sub_n < half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      clk_q <= 1'b0;
    end else begin
      sub_q <= sub_n;
      clk_q <= clk_n;
    end
  end

  // R3: the divider count stays inside one ratio span
  a_r3_sub_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_q != '0) |-> (sub_q < div_n || !run_n));
endmodule

// File: rtl/ets_clock_gen.sv
module ets_clock_gen #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] div_ratio,
  input  logic [CNT_W-1:0] period_len,
  output logic             adc_clk,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] phase_idx
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             cfg_ok;
  logic             run_q, run_n, done_q;
  logic [CNT_W-1:0] pos_q, pos_n, ph_q, ph_n, div_q, div_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ets_cfg_check #(.CNT_W(CNT_W)) u_cfg (
    .div_in (div_ratio),
    .per_in (period_len),
    .cfg_ok (cfg_ok)
  );

  ets_sweep_ctrl #(.CNT_W(CNT_W)) u_sweep (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (start),
    .cfg_ok (cfg_ok),
    .div_in (div_ratio),
    .per_in (period_len),
    .run_q  (run_q),
    .run_n  (run_n),
    .done_q (done_q),
    .pos_q  (pos_q),
    .pos_n  (pos_n),
    .ph_q   (ph_q),
    .ph_n   (ph_n),
    .div_q  (div_q),
    .div_n  (div_n)
  );

  ets_phase_div #(.CNT_W(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run_n (run_n),
    .pos_n (pos_n),
    .ph_n  (ph_n),
    .div_n (div_n),
    .clk_q (adc_clk)
  );

  assign busy      = run_q;
  assign done      = done_q;
  assign phase_idx = ph_q;

  // R3: the conversion clock only runs during a sweep
  a_r3_clk_in_sweep: assert property (@(posedge clk) disable iff (!rst_int_n)
    adc_clk |-> busy);
  // R3: no sample edge before the period's phase offset
  a_r3_edge_after_offset: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(adc_clk) |-> (pos_q >= ph_q));
  // R5: clock is low when the sweep completes
  a_r5_clk_low_done: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> !adc_clk);
endmodule

// File: tb/ets_clock_gen_tb.sv
module ets_clock_gen_tb;
  localparam int W = 12;

  typedef struct {
    logic       adc;
    logic       bsy;
    logic       dn;
    int         ph;
    string      tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [W-1:0] div_ratio;
  logic [W-1:0] period_len;
  logic         adc_clk, busy, done;
  logic [W-1:0] phase_idx;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  ets_clock_gen #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .div_ratio(div_ratio), .period_len(period_len),
    .adc_clk(adc_clk), .busy(busy), .done(done), .phase_idx(phase_idx)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: compare each produced cycle with the scoreboard head
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      cmp(e.tag, "adc_clk", int'(adc_clk), int'(e.adc));
      cmp(e.tag, "busy", int'(busy), int'(e.bsy));
      cmp(e.tag, "done", int'(done), int'(e.dn));
      cmp(e.tag, "phase_idx", int'(phase_idx), e.ph);
    end
  end

  function automatic exp_t mk(logic a, logic b, logic d, int p, string t);
    exp_t e;
    e.adc = a; e.bsy = b; e.dn = d; e.ph = p; e.tag = t;
    return e;
  endfunction

  // driver: issue a start, push the expected cycles, optionally disturb
  task automatic run_cfg(input int dv, input int per, input bit disturb);
    bit ok;
    ok = (dv >= 2) && (per >= dv);
    @(negedge clk);
    div_ratio  = W'(dv);
    period_len = W'(per);
    start      = 1'b1;
    @(posedge clk);
    if (ok) begin
      for (int c = 0; c < dv * per; c++) begin
        int pos, p;
        logic a;
        pos = c % per;
        p   = c / per;
        a   = (pos >= p) && (((pos - p) % dv) < (dv / 2));
        sb_q.push_back(mk(a, 1'b1, 1'b0, p, disturb ? "R3/R4/R7/R8" : "R2/R3/R4"));
      end
      sb_q.push_back(mk(1'b0, 1'b0, 1'b1, 0, "R5"));
    end else begin
      sb_q.push_back(mk(1'b0, 1'b0, 1'b1, 0, "R6"));
    end
    sb_q.push_back(mk(1'b0, 1'b0, 1'b0, 0, ok ? "R5" : "R6"));
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; sb_q.size() > 0; k++) begin
      if (disturb && k == 4) begin
        start = 1'b1; div_ratio = W'(2); period_len = W'(3);
      end else if (disturb && k == 5) begin
        start = 1'b0; div_ratio = W'(7); period_len = W'(40);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; div_ratio = '0; period_len = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp("R1", "adc_clk", int'(adc_clk), 0);
    cmp("R1", "busy", int'(busy), 0);
    cmp("R1", "done", int'(done), 0);
    cmp("R1", "phase_idx", int'(phase_idx), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp("R1", "busy after release", int'(busy), 0);
    cmp("R1", "adc_clk after release", int'(adc_clk), 0);

    run_cfg(4, 8, 0);    // R2 R3 even ratio, whole multiple
    run_cfg(3, 7, 0);    // R3 odd ratio, truncated pulses
    run_cfg(2, 6, 0);
    run_cfg(4, 4, 0);    // period equal to ratio
    run_cfg(5, 6, 0);    // period just above ratio
    run_cfg(1, 8, 0);    // R6 ratio 1
    run_cfg(0, 8, 0);    // R6 ratio 0
    run_cfg(6, 5, 0);    // R6 period shorter than ratio
    run_cfg(4, 10, 1);   // R7 R8 start and new inputs during sweep
    repeat (3) @(negedge clk);
    cmp("R5", "idle busy", int'(busy), 0);
    cmp("R5", "idle done", int'(done), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule